// File: doc/BRIEF.md
# Drink Vending Sale Controller

This block runs one sale at a time for a dispenser with three drinks. A 3-bit selector chooses the drink, and four coin inputs each carry a single-cycle pulse that has already been debounced. Every amount inside the block is an integer count of tenths of a unit. The block adds up what the customer has paid and compares that total with the price. Once the customer has paid enough, it works out the change.

The block moves through four phases: idle, select, pay and change. A minimum time in pay keeps the paid amount on the display long enough to read. A fixed time in change shows the change before the next customer. One status LED shows how the payment compares with the price: a fast blink means underpaid, steady on means exact, and a slow blink means overpaid.

For a display driver, the block outputs the phase code and a three-digit BCD value. The lowest digit is the tenths place, and a decimal-point mask marks the middle digit. A single iterative binary-to-BCD converter runs over and over and fills in the digits. All time constants are parameters, so a simulation can use short periods.

Top module: `vend_sale_ctrl`

## Requirements
- R1: Selector codes 1, 2 and 3 set prices of 10, 35 and 50 tenths. Codes 0 and 4 to 7 are not a valid selection, and the block stays in idle while one of them is applied.
- R2: The half, one, five and ten coin pulses add 5, 10, 50 and 100 tenths to the paid total. The total saturates at 999. A pulse outside the select and pay phases has no effect.
- R3: `phase` is one-hot: bit 0 is idle, bit 1 select, bit 2 pay and bit 3 change. Idle moves to select while a valid code is applied. Select moves to pay on the first coin pulse.
- R4: Pay moves to change only when the paid total is at least the price and pay has lasted PAY_SECS*SEC_CYC cycles. If the total is enough from the start, pay lasts exactly that long.
- R5: Change lasts exactly CHG_SECS*SEC_CYC cycles and then returns to idle, clearing the paid total and the change. The selector is ignored during change.
- R6: `disp_bcd` holds three BCD digits (bits 3:0 are tenths, 7:4 units, 11:8 tens). It shows the price in select, the paid total in pay, the change in change and zero in idle. It updates within 2*(10+1) cycles of a change in its source. `disp_dp` is always 3'b010.
- R7: `led` is off in idle and while the code is invalid. When the paid total is below the price, `led` toggles every FAST_CYC cycles. When the total equals the price, `led` is steadily on. When the total is above the price, `led` toggles every SEC_CYC cycles.
- R8: An invalid code during select or pay returns the block to idle and clears the paid total. The next sale starts from zero.
- R9: The change is the paid total minus the price. It is captured when the block enters the change phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| product | input | 3 | Drink selector code |
| coin_half | input | 1 | Pulse worth 5 tenths |
| coin_one | input | 1 | Pulse worth 10 tenths |
| coin_five | input | 1 | Pulse worth 50 tenths |
| coin_ten | input | 1 | Pulse worth 100 tenths |
| phase | output | 4 | One-hot phase code |
| disp_bcd | output | 12 | Three BCD digits to display |
| disp_dp | output | 3 | Decimal-point enable per digit |
| led | output | 1 | Status LED |

## Verification
The assertions assume the following about the inputs:
- Each coin input is a clean pulse that needs no filtering.
- The selector may change at any cycle.
- The block's own counters are the only record of elapsed time.

The stimulus drives every input on the falling clock edge. It holds each coin high for exactly one cycle, or for back-to-back cycles when it means consecutive coins. Before the change phase ends, it returns the selector to zero so that idle is not left at once. The bench uses short second and blink periods, so the dwell-time and blink-period checks count exact cycles.

// File: rtl/vend_sale_ctrl.sv
module vend_sale_ctrl #(
  parameter int SEC_CYC  = 50_000_000,
  parameter int FAST_CYC = 5_000_000,
  parameter int PAY_SECS = 1,
  parameter int CHG_SECS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  product,
  input  logic        coin_half,
  input  logic        coin_one,
  input  logic        coin_five,
  input  logic        coin_ten,
  output logic [3:0]  phase,
  output logic [11:0] disp_bcd,
  output logic [2:0]  disp_dp,
  output logic        led
);
  localparam int AW      = 10;
  localparam int DW      = 12;
  localparam int SW      = AW + DW;
  localparam int MAX_AMT = 999;
  localparam int PAY_CYC = PAY_SECS * SEC_CYC;
  localparam int CHG_CYC = CHG_SECS * SEC_CYC;
  localparam int TW      = $clog2(CHG_CYC > PAY_CYC ? CHG_CYC : PAY_CYC) + 1;
  localparam int BW      = $clog2(SEC_CYC > FAST_CYC ? SEC_CYC : FAST_CYC) + 1;
  localparam int CW      = $clog2(AW) + 1;

  localparam logic [3:0] PH_IDLE = 4'b0001;
  localparam logic [3:0] PH_SEL  = 4'b0010;
  localparam logic [3:0] PH_PAY  = 4'b0100;
  localparam logic [3:0] PH_CHG  = 4'b1000;

  localparam logic [1:0] LM_OFF  = 2'd0;
  localparam logic [1:0] LM_FAST = 2'd1;
  localparam logic [1:0] LM_ON   = 2'd2;
  localparam logic [1:0] LM_SLOW = 2'd3;

  logic [AW-1:0] price_lv, price_q, eff_price, paid, chg, paid_nx, src;
  logic [AW:0]   coin_sum, sum_raw;
  logic          prod_ok, coin_any, coin_ok;
  logic [3:0]    ph_nx;
  logic [TW-1:0] tmr;

  always_comb begin
    case (product)
      3'd1:    price_lv = AW'(10);
      3'd2:    price_lv = AW'(35);
      3'd3:    price_lv = AW'(50);
      default: price_lv = '0;
    endcase
  end

  assign prod_ok   = (price_lv != '0);
  assign eff_price = (phase == PH_CHG) ? price_q : price_lv;
  assign coin_any  = coin_half | coin_one | coin_five | coin_ten;
  assign coin_ok   = ((phase == PH_SEL) || (phase == PH_PAY)) && prod_ok;
  assign coin_sum  = (coin_half ? (AW+1)'(5)   : '0) + (coin_one ? (AW+1)'(10)  : '0)
                   + (coin_five ? (AW+1)'(50)  : '0) + (coin_ten ? (AW+1)'(100) : '0);
  assign sum_raw   = {1'b0, paid} + coin_sum;
  assign paid_nx   = (sum_raw > (AW+1)'(MAX_AMT)) ? AW'(MAX_AMT) : sum_raw[AW-1:0];
  assign disp_dp   = 3'b010;

  always_comb begin
    ph_nx = phase;
    case (phase)
      PH_IDLE: if (prod_ok) ph_nx = PH_SEL;
      PH_SEL:  if (!prod_ok) ph_nx = PH_IDLE;
               else if (coin_any) ph_nx = PH_PAY;
      PH_PAY:  if (!prod_ok) ph_nx = PH_IDLE;
               else if (paid >= price_lv && tmr >= TW'(PAY_CYC - 1)) ph_nx = PH_CHG;
      PH_CHG:  if (tmr == TW'(CHG_CYC - 1)) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tmr     <= '0;
      paid    <= '0;
      chg     <= '0;
      price_q <= '0;
    end else begin
      phase <= ph_nx;
      if (ph_nx != phase) tmr <= '0;
      else if (phase == PH_PAY && tmr >= TW'(PAY_CYC - 1)) tmr <= tmr;
      else if (phase == PH_PAY || phase == PH_CHG) tmr <= tmr + 1'b1;
      if (ph_nx == PH_IDLE) paid <= '0;
      else if (coin_ok) paid <= paid_nx;
      if (ph_nx == PH_IDLE) chg <= '0;
      else if (phase == PH_PAY && ph_nx == PH_CHG) chg <= paid - price_lv;
      if (phase != PH_CHG) price_q <= price_lv;
    end
  end

  // status LED
  logic [1:0]    mode_c, mode_q;
  logic [BW-1:0] blk;

  always_comb begin
    if (phase == PH_IDLE || eff_price == '0) mode_c = LM_OFF;
    else if (paid < eff_price)               mode_c = LM_FAST;
    else if (paid == eff_price)              mode_c = LM_ON;
    else                                     mode_c = LM_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LM_OFF;
      blk    <= '0;
      led    <= 1'b0;
    end else if (mode_c != mode_q) begin
      mode_q <= mode_c;
      blk    <= '0;
      led    <= (mode_c != LM_OFF);
    end else begin
      case (mode_q)
        LM_FAST: if (blk == BW'(FAST_CYC - 1)) begin blk <= '0; led <= ~led; end
                 else blk <= blk + 1'b1;
        LM_SLOW: if (blk == BW'(SEC_CYC - 1)) begin blk <= '0; led <= ~led; end
                 else blk <= blk + 1'b1;
        LM_ON:   led <= 1'b1;
        default: led <= 1'b0;
      endcase
    end
  end

  // iterative binary to BCD
  always_comb begin
    case (phase)
      PH_SEL:  src = price_lv;
      PH_PAY:  src = paid;
      PH_CHG:  src = chg;
      default: src = '0;
    endcase
  end

  logic [SW-1:0] cv_sh, cv_adj, cv_shl;
  logic [CW-1:0] cv_cnt;
  logic          cv_busy, conv_done;

  always_comb begin
    cv_adj = cv_sh;
    for (int d = 0; d < DW / 4; d++)
      if (cv_adj[AW + 4*d +: 4] >= 4'd5) cv_adj[AW + 4*d +: 4] = cv_adj[AW + 4*d +: 4] + 4'd3;
    cv_shl = cv_adj << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_sh     <= '0;
      cv_cnt    <= '0;
      cv_busy   <= 1'b0;
      conv_done <= 1'b0;
      disp_bcd  <= '0;
    end else if (!cv_busy) begin
      cv_sh     <= {{DW{1'b0}}, src};
      cv_cnt    <= '0;
      cv_busy   <= 1'b1;
      conv_done <= 1'b0;
    end else begin
      cv_sh  <= cv_shl;
      cv_cnt <= cv_cnt + 1'b1;
      if (cv_cnt == CW'(AW - 1)) begin
        cv_busy   <= 1'b0;
        conv_done <= 1'b1;
        disp_bcd  <= cv_shl[SW-1:AW];
      end else begin
        conv_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vend_sale_ctrl_chk.sv
module vend_sale_ctrl_chk #(
  parameter int PAY_CYC = 50_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  phase,
  input logic        led,
  input logic [11:0] disp_bcd,
  input logic [9:0]  paid,
  input logic [9:0]  eff_price,
  input logic        conv_done
);
  localparam int PW = $clog2(PAY_CYC + 1) + 1;
  logic [PW-1:0] pay_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pay_cnt <= '0;
    else if (!phase[2]) pay_cnt <= '0;
    else if (pay_cnt < PW'(PAY_CYC)) pay_cnt <= pay_cnt + 1'b1;
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1); // R3
  AST_PAID_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    paid <= 10'd999); // R2
  AST_CHANGE_NEEDS_PAID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase[3]) |-> $past(paid) >= $past(eff_price)); // R4
  AST_PAY_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase[3]) |-> pay_cnt >= PW'(PAY_CYC)); // R4
  AST_CHANGE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase[3]) |-> phase[0]); // R5
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |-> paid == 10'd0); // R8
  AST_IDLE_LED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] && $past(phase[0]) |-> !led); // R7
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_bcd[3:0] <= 4'd9 && disp_bcd[7:4] <= 4'd9 && disp_bcd[11:8] <= 4'd9); // R6
  AST_DISP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_bcd) |-> conv_done); // R6
endmodule

bind vend_sale_ctrl vend_sale_ctrl_chk #(.PAY_CYC(PAY_SECS * SEC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .led(led), .disp_bcd(disp_bcd),
  .paid(paid), .eff_price(eff_price), .conv_done(conv_done));

// File: tb/test_vend_sale_ctrl.sv
module test_vend_sale_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SEC  = 64;
  localparam int FAST = 8;
  localparam int NVEC = 6;
  localparam logic [3:0] P_IDLE = 4'b0001, P_SEL = 4'b0010, P_PAY = 4'b0100, P_CHG = 4'b1000;
  // {product, halves, ones, fives, tens, price bcd, paid bcd, change bcd}
  localparam logic [55:0] VEC [NVEC] = '{
    56'h1_2_0_0_0_010_010_000,
    56'h2_0_0_1_0_035_050_015,
    56'h3_0_0_0_1_050_100_050,
    56'h2_1_3_0_0_035_035_000,
    56'h1_1_1_1_1_010_165_155,
    56'h3_0_0_2_9_050_999_949
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] product = '0;
  logic coin_half = 0, coin_one = 0, coin_five = 0, coin_ten = 0;
  logic [3:0] phase;
  logic [11:0] disp_bcd;
  logic [2:0] disp_dp;
  logic led;
  int n_chk = 0, n_bad = 0;
  int run = 0, last_pay = 0, last_chg = 0;
  logic [3:0] prev_ph = 4'b0001;

  vend_sale_ctrl #(.SEC_CYC(SEC), .FAST_CYC(FAST), .PAY_SECS(1), .CHG_SECS(5)) i_vend_sale_ctrl (
    .clk(clk), .rst_n(rst_n), .product(product), .coin_half(coin_half), .coin_one(coin_one),
    .coin_five(coin_five), .coin_ten(coin_ten), .phase(phase), .disp_bcd(disp_bcd),
    .disp_dp(disp_dp), .led(led));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (phase == prev_ph) run++;
    else begin
      if (prev_ph == P_PAY) last_pay = run;
      if (prev_ph == P_CHG) last_chg = run;
      run = 1;
    end
    prev_ph = phase;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic coin(input int kind);
    case (kind)
      0: coin_half = 1; 1: coin_one = 1; 2: coin_five = 1; default: coin_ten = 1;
    endcase
    @(negedge clk);
    coin_half = 0; coin_one = 0; coin_five = 0; coin_ten = 0;
  endtask

  task automatic wait_ph(input logic [3:0] p);
    for (int k = 0; k < 2000 && phase != p; k++) @(negedge clk);
  endtask

  task automatic toggles(input int n, output int t);
    logic pv;
    pv = led; t = 0;
    repeat (n) begin @(negedge clk); if (led != pv) t++; pv = led; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R3 reset phase", phase, P_IDLE);
    chk("R6 reset display", disp_bcd, 0);
    chk("R6 decimal point", disp_dp, 3'b010);
    chk("R7 reset led", led, 0);

    product = 3'd5; cyc(20);
    chk("R1 invalid code stays idle", phase, P_IDLE);
    chk("R7 led off invalid", led, 0);
    product = 3'd0;
    coin(3); cyc(2);
    product = 3'd1; cyc(30);
    chk("R3 select", phase, P_SEL);
    coin(0); cyc(28);
    chk("R2 idle coin ignored", disp_bcd, 12'h005);
    toggles(64, t);
    chk("R7 fast blink toggles", t, SEC / FAST);

    product = 3'd0; cyc(30);
    chk("R8 abort to idle", phase, P_IDLE);
    chk("R8 display zero", disp_bcd, 0);
    chk("R7 led off after abort", led, 0);
    product = 3'd2; cyc(30);
    chk("R1 price 3.5", disp_bcd, 12'h035);
    coin(0); cyc(28);
    chk("R8 paid restarted", disp_bcd, 12'h005);
    product = 3'd6; cyc(5);
    chk("R8 invalid code aborts pay", phase, P_IDLE);
    product = 3'd0; cyc(5);

    product = 3'd1; cyc(30);
    coin(2); cyc(10);
    toggles(128, t);
    chk("R7 slow blink toggles", t, 2);
    chk("R5 in change", phase, P_CHG);
    product = 3'd0; cyc(30);
    chk("R9 change 4.0", disp_bcd, 12'h040);
    coin(3); cyc(30);
    chk("R2 change coin ignored", disp_bcd, 12'h040);
    wait_ph(P_IDLE);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] p, nh, n1, n5, n10;
      logic [11:0] ep, epd, ec;
      {p, nh, n1, n5, n10, ep, epd, ec} = VEC[v];
      product = p[2:0]; cyc(30);
      chk("R3 vector select", phase, P_SEL);
      chk("R1 vector price", disp_bcd, ep);
      for (int k = 0; k < n10; k++) coin(3);
      for (int k = 0; k < n5; k++)  coin(2);
      for (int k = 0; k < n1; k++)  coin(1);
      for (int k = 0; k < nh; k++)  coin(0);
      cyc(28);
      chk("R3 vector pay", phase, P_PAY);
      chk("R2 vector paid", disp_bcd, epd);
      if (epd == ep) chk("R7 exact steady led", led, 1);
      wait_ph(P_CHG);
      product = 3'd0; cyc(30);
      chk("R5 selector ignored in change", phase, P_CHG);
      chk("R9 vector change", disp_bcd, ec);
      wait_ph(P_IDLE);
      cyc(1);
      chk("R4 pay dwell", last_pay, SEC);
      chk("R5 change dwell", last_chg, 5 * SEC);
      cyc(30);
      chk("R5 idle display cleared", disp_bcd, 0);
      chk("R7 idle led off", led, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule